// File: doc/BRIEF.md
# Class-Selective Downstream Port Register Bank

This block holds the configuration registers of one downstream switch port. Each register bit has a persistence class. When the secondary bus reset sequencer raises its reset-active line, ordinary bits go back to their initial values. Bits of the two sticky classes keep their values, and read-only bits never change. A power-on reset, by contrast, returns every bit to its default.

Two parallel register ports reach the bank. The primary port carries configuration reads and writes. The sideband port serves a management controller whose serial protocol is decoded elsewhere. Both ports keep running while the secondary reset is active.

During that reset the two ports see different things:
- The primary port reads live contents. Its writes still land in sticky-class bits.
- The sideband port treats any register that contains at least one ordinary bit as held in reset. A read of such a register returns its full default value, and a write to it is dropped.

Both ports are plain single-cycle strobes with no back-pressure. A write is taken at the clock edge where its enable is high. Read data follows the address combinationally in the same cycle.

Top module: `spr_port_regs`

## Requirements
- R1: While the active-low power-on reset `rst_n` is low, and after it is released, every register reads its default on both ports, sticky-class bits included. The default of register i is {8'hA5, i[7:0], 16'h0F0F}.
- R2: Bit classes use the 2-bit code 00 ordinary, 01 sticky, 10 software-sticky, 11 read-only. Register 0 is all read-only, register 1 all sticky, register 2 all software-sticky, and odd registers from 3 up are all ordinary. Even registers from 4 up have bits [31:24] read-only, [23:16] sticky, [15:8] software-sticky and [7:0] ordinary. Read-only bits ignore writes from both ports.
- R3: With `sbr_active` low, a write from either port updates the writable bits at that clock edge. Either port can read the new value right after that edge.
- R4: At every clock edge where `sbr_active` is high, ordinary bits load their defaults. Primary writes to ordinary bits have no effect during that time.
- R5: Sticky and software-sticky bits keep their values across a secondary reset, and primary writes to them still take effect while `sbr_active` is high.
- R6: While `sbr_active` is high, a sideband read of a register that has any ordinary bit (registers 3 and up) returns that register's default. A sideband read of registers 0 to 2 returns live contents.
- R7: While `sbr_active` is high, a sideband write to a register that has any ordinary bit is dropped entirely. Sideband writes to registers 0 to 2 still take effect.
- R8: When both ports write the same register in one cycle, the primary data is stored. When they write different registers, both writes land.
- R9: Once `sbr_active` falls, both ports write ordinary bits again from the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| sbr_active | input | 1 | Secondary bus reset in progress, from the sequencer |
| pri_we | input | 1 | Primary port write strobe |
| pri_addr | input | ADDR_W | Primary port register index |
| pri_wdata | input | 32 | Primary port write data |
| pri_rdata | output | 32 | Primary port read data, live contents |
| sb_we | input | 1 | Sideband port write strobe |
| sb_addr | input | ADDR_W | Sideband port register index |
| sb_wdata | input | 32 | Sideband port write data |
| sb_rdata | output | 32 | Sideband port read data, defaults for reset-held registers |

## Verification
There are two ways a wrong class decode can go:
- A bit is wrongly treated as ordinary. A value written before the reset then reads back as the default one cycle after `sbr_active` rises.
- A bit is wrongly treated as sticky. It keeps a stale value through the same window.

A faulty sideband gate is visible in the same cycle as the read. It also leaves a dropped write present after the reset ends, which a later sideband read of that register exposes. An arbitration error appears one edge after a same-register collision, as sideband data on the primary read.

// File: rtl/spr_pkg.sv
package spr_pkg;

  localparam int DATA_W = 32;
  localparam int QTR_W  = DATA_W / 4;

  typedef enum logic [1:0] {
    FC_NORMAL   = 2'b00,
    FC_STICKY   = 2'b01,
    FC_SWSTICKY = 2'b10,
    FC_RDONLY   = 2'b11
  } fclass_e;

  // Persistence class of bit b of register r.
  function automatic fclass_e bit_class(input int r, input int b);
    if (r == 0) return FC_RDONLY;
    if (r == 1) return FC_STICKY;
    if (r == 2) return FC_SWSTICKY;
    if ((r % 2) == 1) return FC_NORMAL;
    case (b / QTR_W)
      3:       return FC_RDONLY;
      2:       return FC_STICKY;
      1:       return FC_SWSTICKY;
      default: return FC_NORMAL;
    endcase
  endfunction

  // Packed two-bit-per-bit class vector of one register.
  function automatic logic [2*DATA_W-1:0] class_vec(input int r);
    logic [2*DATA_W-1:0] v;
    v = '0;
    for (int b = 0; b < DATA_W; b++) v[2*b +: 2] = bit_class(r, b);
    return v;
  endfunction

  function automatic logic [DATA_W-1:0] class_mask(input int r, input fclass_e c);
    logic [2*DATA_W-1:0] cv;
    logic [DATA_W-1:0]   m;
    cv = class_vec(r);
    m  = '0;
    for (int b = 0; b < DATA_W; b++) m[b] = (cv[2*b +: 2] == c);
    return m;
  endfunction

  function automatic logic [DATA_W-1:0] keep_mask(input int r);
    return class_mask(r, FC_STICKY) | class_mask(r, FC_SWSTICKY);
  endfunction

  function automatic logic reg_affected(input int r);
    return |class_mask(r, FC_NORMAL);
  endfunction

  function automatic logic [DATA_W-1:0] reg_default(input int r);
    return {8'hA5, 8'(r), 16'h0F0F};
  endfunction

endpackage

// File: rtl/spr_write_arb.sv
module spr_write_arb
  import spr_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int ADDR_W   = 3
) (
  input  logic                             sbr_active,
  input  logic                             pri_we,
  input  logic [ADDR_W-1:0]                pri_addr,
  input  logic [DATA_W-1:0]                pri_wdata,
  input  logic                             sb_we,
  input  logic [ADDR_W-1:0]                sb_addr,
  input  logic [DATA_W-1:0]                sb_wdata,
  output logic [NUM_REGS-1:0]              wen,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  wdata
);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
    localparam logic HELD = reg_affected(i);
    logic pri_hit;
    logic sb_hit;

    assign pri_hit  = pri_we && (pri_addr == ADDR_W'(i));
    // Sideband writes to a reset-held register are discarded.
    assign sb_hit   = sb_we && (sb_addr == ADDR_W'(i)) && !(sbr_active && HELD);
    assign wen[i]   = pri_hit || sb_hit;
    // Primary port takes precedence on a same-register collision.
    assign wdata[i] = pri_hit ? pri_wdata : sb_wdata;
  end

endmodule

// File: rtl/spr_reg_slot.sv
module spr_reg_slot
  import spr_pkg::*;
#(
  parameter int REG_IDX = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sbr_active,
  input  logic              wen,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);

  localparam logic [DATA_W-1:0] DEF = reg_default(REG_IDX);

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    localparam fclass_e CLS = bit_class(REG_IDX, b);
    logic bit_q;

    if (CLS == FC_RDONLY) begin : g_ro
      assign bit_q = DEF[b];
    end else if (CLS == FC_NORMAL) begin : g_norm
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          bit_q <= DEF[b];
        else if (sbr_active) bit_q <= DEF[b];
        else if (wen)        bit_q <= wdata[b];
      end
    end else begin : g_keep
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   bit_q <= DEF[b];
        else if (wen) bit_q <= wdata[b];
      end
    end

    assign q[b] = bit_q;
  end

  // Some class layouts leave inputs without a reader.
  logic unused_sink;
  assign unused_sink = ^{clk, rst_n, sbr_active, wen, wdata};

endmodule

// File: rtl/spr_read_port.sv
module spr_read_port
  import spr_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int ADDR_W   = 3,
  parameter bit SUBST    = 1'b0
) (
  input  logic                            sbr_active,
  input  logic [ADDR_W-1:0]               addr,
  input  logic [NUM_REGS-1:0][DATA_W-1:0] live,
  output logic [DATA_W-1:0]               rdata
);

  logic [NUM_REGS-1:0][DATA_W-1:0] view;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_view
    if (SUBST && reg_affected(i)) begin : g_sub
      assign view[i] = sbr_active ? reg_default(i) : live[i];
    end else begin : g_live
      assign view[i] = live[i];
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (addr == ADDR_W'(i)) rdata = view[i];
  end

  logic unused_sink;
  assign unused_sink = sbr_active;

endmodule

// File: rtl/spr_port_regs.sv
module spr_port_regs
  import spr_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int ADDR_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sbr_active,
  input  logic              pri_we,
  input  logic [ADDR_W-1:0] pri_addr,
  input  logic [31:0]       pri_wdata,
  output logic [31:0]       pri_rdata,
  input  logic              sb_we,
  input  logic [ADDR_W-1:0] sb_addr,
  input  logic [31:0]       sb_wdata,
  output logic [31:0]       sb_rdata
);

  logic [NUM_REGS-1:0]             wen;
  logic [NUM_REGS-1:0][DATA_W-1:0] wdata;
  logic [NUM_REGS-1:0][DATA_W-1:0] live_q;

  spr_write_arb #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_arb (
    .sbr_active (sbr_active),
    .pri_we     (pri_we),
    .pri_addr   (pri_addr),
    .pri_wdata  (pri_wdata),
    .sb_we      (sb_we),
    .sb_addr    (sb_addr),
    .sb_wdata   (sb_wdata),
    .wen        (wen),
    .wdata      (wdata)
  );

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    spr_reg_slot #(.REG_IDX(i)) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .sbr_active (sbr_active),
      .wen        (wen[i]),
      .wdata      (wdata[i]),
      .q          (live_q[i])
    );
  end

  spr_read_port #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .SUBST(1'b0)) u_rd_pri (
    .sbr_active (sbr_active),
    .addr       (pri_addr),
    .live       (live_q),
    .rdata      (pri_rdata)
  );

  spr_read_port #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .SUBST(1'b1)) u_rd_sb (
    .sbr_active (sbr_active),
    .addr       (sb_addr),
    .live       (live_q),
    .rdata      (sb_rdata)
  );

endmodule

// File: rtl/spr_port_regs_chk.sv
module spr_port_regs_chk
  import spr_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int ADDR_W   = 3
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            sbr_active,
  input logic                            pri_we,
  input logic [ADDR_W-1:0]               pri_addr,
  input logic [DATA_W-1:0]               pri_wdata,
  input logic                            sb_we,
  input logic [ADDR_W-1:0]               sb_addr,
  input logic [DATA_W-1:0]               sb_rdata,
  input logic [NUM_REGS-1:0][DATA_W-1:0] live_q
);

  logic sbr_d;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sbr_d <= 1'b0;
    else        sbr_d <= sbr_active;
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_chk
    localparam logic [DATA_W-1:0] DEF   = reg_default(i);
    localparam logic [DATA_W-1:0] NMASK = class_mask(i, FC_NORMAL);
    localparam logic [DATA_W-1:0] KMASK = keep_mask(i);
    localparam logic [DATA_W-1:0] RMASK = class_mask(i, FC_RDONLY);
    localparam logic              AFF   = reg_affected(i);

    p_por_default_r1: assert property (@(posedge clk)
      $rose(rst_n) |-> (live_q[i] == DEF));

    p_normal_cleared_r4: assert property (@(posedge clk) disable iff (!rst_n)
      sbr_active |=> ((live_q[i] & NMASK) == (DEF & NMASK)));

    p_sticky_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (sbr_active && !pri_we && !sb_we) |=> ((live_q[i] & KMASK) == $past(live_q[i] & KMASK)));

    p_sb_default_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (sbr_active && AFF && (sb_addr == ADDR_W'(i))) |-> (sb_rdata == DEF));

    p_sb_write_dropped_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (sbr_active && sbr_d && AFF && sb_we && (sb_addr == ADDR_W'(i)) &&
       !(pri_we && (pri_addr == ADDR_W'(i)))) |=> $stable(live_q[i]));

    p_primary_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!sbr_active && pri_we && sb_we && (pri_addr == ADDR_W'(i)) && (sb_addr == ADDR_W'(i)))
      |=> ((live_q[i] & ~RMASK) == ($past(pri_wdata) & ~RMASK)));
  end

endmodule

bind spr_port_regs spr_port_regs_chk #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sbr_active (sbr_active),
  .pri_we     (pri_we),
  .pri_addr   (pri_addr),
  .pri_wdata  (pri_wdata),
  .sb_we      (sb_we),
  .sb_addr    (sb_addr),
  .sb_rdata   (sb_rdata),
  .live_q     (live_q)
);

// File: tb/spr_port_regs_tb.sv
module spr_port_regs_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sbr_active = 1'b0;
  logic        pri_we = 1'b0;
  logic [2:0]  pri_addr = '0;
  logic [31:0] pri_wdata = '0;
  logic [31:0] pri_rdata;
  logic        sb_we = 1'b0;
  logic [2:0]  sb_addr = '0;
  logic [31:0] sb_wdata = '0;
  logic [31:0] sb_rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  spr_port_regs #(.NUM_REGS(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .sbr_active(sbr_active),
    .pri_we(pri_we), .pri_addr(pri_addr), .pri_wdata(pri_wdata), .pri_rdata(pri_rdata),
    .sb_we(sb_we), .sb_addr(sb_addr), .sb_wdata(sb_wdata), .sb_rdata(sb_rdata)
  );

  typedef struct packed {
    logic        pw;  logic [2:0] pa; logic [31:0] pd;
    logic        sw;  logic [2:0] sa; logic [31:0] sd;
    logic        sbr; logic       on_sb; logic [2:0] ca;
    logic [31:0] exp; logic [3:0] req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{1'b1,3'd3,32'h12345678, 1'b0,3'd0,32'h0,        1'b0,1'b0,3'd3,32'h12345678,4'd3}, // R3 primary write
    '{1'b0,3'd0,32'h0,        1'b1,3'd4,32'hFFFFFFFF, 1'b0,1'b1,3'd4,32'hA5FFFFFF,4'd2}, // R2 RO bits kept
    '{1'b1,3'd0,32'h0,        1'b0,3'd0,32'h0,        1'b0,1'b0,3'd0,32'hA5000F0F,4'd2}, // R2 RO register
    '{1'b1,3'd1,32'hDEADBEEF, 1'b0,3'd0,32'h0,        1'b0,1'b0,3'd1,32'hDEADBEEF,4'd3}, // R3
    '{1'b1,3'd5,32'h11111111, 1'b1,3'd5,32'h22222222, 1'b0,1'b1,3'd5,32'h11111111,4'd8}, // R8 collision
    '{1'b1,3'd6,32'h0,        1'b1,3'd7,32'h77777777, 1'b0,1'b1,3'd7,32'h77777777,4'd8}, // R8 distinct
    '{1'b0,3'd0,32'h0,        1'b0,3'd0,32'h0,        1'b1,1'b0,3'd3,32'hA5030F0F,4'd4}, // R4 cleared
    '{1'b0,3'd0,32'h0,        1'b0,3'd0,32'h0,        1'b1,1'b0,3'd4,32'hA5FFFF0F,4'd5}, // R5 mixed kept
    '{1'b0,3'd0,32'h0,        1'b0,3'd0,32'h0,        1'b1,1'b1,3'd4,32'hA5040F0F,4'd6}, // R6 default seen
    '{1'b0,3'd0,32'h0,        1'b0,3'd0,32'h0,        1'b1,1'b1,3'd1,32'hDEADBEEF,4'd6}, // R6 live unaffected
    '{1'b0,3'd0,32'h0,        1'b1,3'd6,32'h12345678, 1'b1,1'b0,3'd6,32'hA500000F,4'd7}, // R7 dropped
    '{1'b0,3'd0,32'h0,        1'b1,3'd2,32'hCAFEF00D, 1'b1,1'b1,3'd2,32'hCAFEF00D,4'd7}, // R7 unaffected lands
    '{1'b1,3'd6,32'h12345678, 1'b0,3'd0,32'h0,        1'b1,1'b0,3'd6,32'hA534560F,4'd5}, // R5 write in reset
    '{1'b1,3'd3,32'h99999999, 1'b0,3'd0,32'h0,        1'b1,1'b0,3'd3,32'hA5030F0F,4'd4}, // R4 held
    '{1'b1,3'd3,32'h0BADF00D, 1'b0,3'd0,32'h0,        1'b0,1'b1,3'd3,32'h0BADF00D,4'd9}, // R9 resume
    '{1'b0,3'd0,32'h0,        1'b0,3'd0,32'h0,        1'b0,1'b1,3'd6,32'hA534560F,4'd5}, // R5 after reset
    '{1'b0,3'd0,32'h0,        1'b1,3'd5,32'hCCCCCCCC, 1'b0,1'b0,3'd5,32'hCCCCCCCC,4'd9}  // R9 sideband resume
  };

  function automatic logic [31:0] dflt(input int r);
    return {8'hA5, 8'(r), 16'h0F0F};
  endfunction

  task automatic check(input int req, input logic [31:0] got, input logic [31:0] exp,
                       input string what);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL R%0d %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic check_all_defaults(input string what);
    for (int r = 0; r < 8; r++) begin
      @(negedge clk);
      pri_addr = 3'(r);
      sb_addr  = 3'(r);
      #1;
      check(1, pri_rdata, dflt(r), {what, " primary"}); // R1
      check(1, sb_rdata,  dflt(r), {what, " sideband"}); // R1
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check_all_defaults("reset held");
    rst_n = 1'b1;
    check_all_defaults("after release");

    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      sbr_active = VECS[k].sbr;
      pri_we     = VECS[k].pw;
      pri_addr   = VECS[k].pa;
      pri_wdata  = VECS[k].pd;
      sb_we      = VECS[k].sw;
      sb_addr    = VECS[k].sa;
      sb_wdata   = VECS[k].sd;
      @(negedge clk);
      pri_we   = 1'b0;
      sb_we    = 1'b0;
      pri_addr = VECS[k].ca;
      sb_addr  = VECS[k].ca;
      #1;
      check(int'(VECS[k].req), VECS[k].on_sb ? sb_rdata : pri_rdata, VECS[k].exp,
            $sformatf("vector %0d", k));
    end

    // R6: the sideband view switches to defaults in the same cycle sbr_active rises.
    @(negedge clk);
    sb_addr = 3'd6;
    pri_addr = 3'd6;
    sbr_active = 1'b1;
    #1;
    check(6, sb_rdata, dflt(6), "sideband default before first reset edge");
    check(6, pri_rdata, 32'hA534560F, "primary live before first reset edge");
    @(negedge clk);
    sbr_active = 1'b0;

    // R1: power-on reset also clears sticky-class contents.
    @(negedge clk);
    pri_addr = 3'd1;
    #1;
    check(5, pri_rdata, 32'hDEADBEEF, "sticky value before power-on reset");
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    check_all_defaults("mid-run power-on reset");

    finish_run();
  end

endmodule